// File: doc/BRIEF.md
# Unaligned Load/Store Splitter

This block sits between a load/store pipeline stage and a memory bus that moves only naturally aligned 32-bit words. The bus can be viewed as four byte lanes that share one word address. Because of that, an access that spans two words cannot be served in a single transfer. A request may be a byte, a halfword or a word at any byte address. The block works out which aligned words the access touches and runs one or two bus transfers in sequence.

For loads, the block shifts the returned words and merges them into a right-justified, zero-extended result. For stores, it places the data in the correct lanes of each word and drives a byte-enable mask that covers only the bytes touched. When the block is built with the strict-alignment option, it does not split any access that is not naturally aligned. It returns a fault response instead and performs no bus transfer. Only one request is in flight at a time.

Top module: `lsu_split_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_valid` are 0.
- R2: Every bus transfer carries a word address whose two low bits are zero. The first transfer goes to the word that holds the request's start byte.
- R3: An access whose bytes all lie in one aligned word uses one transfer. An access that spans two words uses two transfers, to consecutive word addresses. Spanning occurs for a halfword at byte offset 3 and for a word at any nonzero offset. `rsp_beats` reports the count, 1 or 2.
- R4: `req_size` encodes byte=0, halfword=1, word=2. The load result is little-endian: the byte at the request address appears in bits 7:0 and the next byte in bits 15:8. Bits above the access size are zero.
- R5: Bit i of `mem_be` enables lane i, which is data bits 8i+7:8i and byte address word+i. Each transfer enables exactly the bytes the access touches in that word, and carries store byte k of `req_wdata` in the lane of byte address addr+k.
- R6: A store leaves every memory byte outside its own range unchanged.
- R7: `req_ready` goes low in the cycle after a request is accepted and stays low until the response. `rsp_valid` is a single-cycle pulse.
- R8: With `STRICT_ALIGN`=1, a halfword at an odd address or a word with a nonzero low address field returns `rsp_fault`=1 and `rsp_beats`=0, with no bus transfer. Aligned accesses complete normally.
- R9: While `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_be` and `mem_wdata` hold their values. Results are unaffected by stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_valid | output | 1 | Bus transfer requested |
| mem_ready | input | 1 | Bus completes the transfer this cycle |
| mem_write | output | 1 | Transfer is a store |
| mem_addr | output | ADDR_W | Aligned word address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Misalignment fault (strict build) |
| rsp_beats | output | 2 | Bus transfers used |
| rsp_rdata | output | 32 | Load result, zero for stores and faults |

## Verification
The assertions assume that the bus returns load data in the same cycle it raises `mem_ready`. They also assume that the requester does not drive the request fields while `req_ready` is low, because those fields are ignored until the block is idle. The stimulus follows both rules. The memory model answers combinationally from the word address it is given, and requests are presented only while the block is idle, held for one accepting edge and then dropped. Stall patterns on `mem_ready` are applied only from the bus side, so the hold properties are tested against a well-behaved requester.

// File: rtl/lsu_split_pkg.sv
`timescale 1ns/1ps
package lsu_split_pkg;
   localparam int LANES  = 4;
   localparam int LANE_W = 8;
   localparam int WORD_W = LANES * LANE_W;
   localparam int OFF_W  = $clog2(LANES);

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_BEAT0,
      ST_BEAT1,
      ST_RESP
   } split_state_e;

   // lanes occupied by an access of the given size starting at lane 0
   function automatic logic [LANES-1:0] size_mask(acc_size_e sz);
      case (sz)
         SZ_BYTE: size_mask = LANES'(1);
         SZ_HALF: size_mask = LANES'(3);
         default: size_mask = '1;
      endcase
   endfunction
endpackage

// File: rtl/lsu_split_lanes.sv
`timescale 1ns/1ps
module lsu_split_lanes
   import lsu_split_pkg::*;
(
   input  acc_size_e             size,
   input  logic [OFF_W-1:0]      off,
   input  logic [WORD_W-1:0]     wdata,
   output logic [LANES-1:0]      be_lo,
   output logic [LANES-1:0]      be_hi,
   output logic [WORD_W-1:0]     wd_lo,
   output logic [WORD_W-1:0]     wd_hi,
   output logic                  crosses,
   output logic                  misaligned
);
   logic [LANES-1:0]    base;
   logic [2*LANES-1:0]  span;
   logic [2*WORD_W-1:0] wide;

   always_comb begin
      base       = size_mask(size);
      span       = {{LANES{1'b0}}, base} << off;
      wide       = {{WORD_W{1'b0}}, wdata} << (off * LANE_W);
      be_lo      = span[LANES-1:0];
      be_hi      = span[2*LANES-1:LANES];
      wd_lo      = wide[WORD_W-1:0];
      wd_hi      = wide[2*WORD_W-1:WORD_W];
      crosses    = |be_hi;
      misaligned = |(off & base[OFF_W:1]);
   end

   // R3: only an access that is not naturally aligned can span two words
   always_comb begin
      a_r3_cross_needs_misalign: assert (!crosses || misaligned);
   end
endmodule

// File: rtl/lsu_split_merge.sv
`timescale 1ns/1ps
module lsu_split_merge
   import lsu_split_pkg::*;
(
   input  acc_size_e          size,
   input  logic [OFF_W-1:0]   off,
   input  logic [WORD_W-1:0]  lo,
   input  logic [WORD_W-1:0]  hi,
   output logic [WORD_W-1:0]  result
);
   logic [LANES-1:0]  keep_lanes;
   logic [WORD_W-1:0] keep;
   logic [WORD_W-1:0] shifted;

   assign keep_lanes = size_mask(size);
   assign shifted    = WORD_W'({hi, lo} >> (off * LANE_W));

   for (genvar g = 0; g < LANES; g++) begin : g_keep
      assign keep[g*LANE_W +: LANE_W] = {LANE_W{keep_lanes[g]}};
   end

   assign result = shifted & keep;
endmodule

// File: rtl/lsu_split_unit.sv
`timescale 1ns/1ps
module lsu_split_unit
   import lsu_split_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit STRICT_ALIGN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [1:0]        rsp_beats,
   output logic [31:0]       rsp_rdata
);
   localparam int WA_W = ADDR_W - OFF_W;

   if (ADDR_W < OFF_W + 2) begin : g_bad_addr_w
      $error("lsu_split_unit: ADDR_W too small");
   end
   if (WORD_W != 32 || LANES != 4) begin : g_bad_word
      $error("lsu_split_unit: port widths assume four byte lanes");
   end

   split_state_e      state;
   logic              r_write;
   acc_size_e         r_size;
   logic [ADDR_W-1:0] r_addr;
   logic [31:0]       r_wdata;
   logic [31:0]       r_lo;
   logic [31:0]       r_hi;
   logic              r_fault;
   logic [1:0]        r_beats;

   logic [LANES-1:0]  be_lo, be_hi;
   logic [WORD_W-1:0] wd_lo, wd_hi, merged;
   logic              crosses, misaligned, fault_req;
   logic [WA_W-1:0]   word_a;

   lsu_split_lanes u_lanes (
      .size       (r_size),
      .off        (r_addr[OFF_W-1:0]),
      .wdata      (r_wdata),
      .be_lo      (be_lo),
      .be_hi      (be_hi),
      .wd_lo      (wd_lo),
      .wd_hi      (wd_hi),
      .crosses    (crosses),
      .misaligned (misaligned)
   );

   lsu_split_merge u_merge (
      .size   (r_size),
      .off    (r_addr[OFF_W-1:0]),
      .lo     (r_lo),
      .hi     (r_hi),
      .result (merged)
   );

   if (STRICT_ALIGN) begin : g_strict
      assign fault_req = misaligned;
   end else begin : g_split
      assign fault_req = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_write <= 1'b0;
         r_size  <= SZ_BYTE;
         r_addr  <= '0;
         r_wdata <= '0;
         r_lo    <= '0;
         r_hi    <= '0;
         r_fault <= 1'b0;
         r_beats <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               r_write <= req_write;
               r_size  <= acc_size_e'(req_size);
               r_addr  <= req_addr;
               r_wdata <= req_wdata;
               r_lo    <= '0;
               r_hi    <= '0;
               r_fault <= 1'b0;
               r_beats <= '0;
               state   <= ST_BEAT0;
            end
            ST_BEAT0: if (fault_req) begin
               r_fault <= 1'b1;
               state   <= ST_RESP;
            end else if (mem_ready) begin
               r_lo    <= mem_rdata;
               r_beats <= 2'd1;
               state   <= crosses ? ST_BEAT1 : ST_RESP;
            end
            ST_BEAT1: if (mem_ready) begin
               r_hi    <= mem_rdata;
               r_beats <= 2'd2;
               state   <= ST_RESP;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign word_a    = r_addr[ADDR_W-1:OFF_W] + WA_W'(state == ST_BEAT1);
   assign req_ready = (state == ST_IDLE);
   assign mem_valid = ((state == ST_BEAT0) && !fault_req) || (state == ST_BEAT1);
   assign mem_write = r_write;
   assign mem_addr  = {word_a, {OFF_W{1'b0}}};
   assign mem_be    = (state == ST_BEAT1) ? be_hi : be_lo;
   assign mem_wdata = (state == ST_BEAT1) ? wd_hi : wd_lo;
   assign rsp_valid = (state == ST_RESP);
   assign rsp_fault = r_fault;
   assign rsp_beats = r_beats;
   assign rsp_rdata = (r_write || r_fault) ? '0 : merged;

   a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                                  && $stable(mem_be) && $stable(mem_wdata));
   a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r5_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_be != '0);
   a_r8_fault_no_beats: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_beats == 2'd0);
   a_r3_next_word: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && mem_ready && state == ST_BEAT0 && crosses
      |=> mem_valid && mem_addr == $past(mem_addr) + ADDR_W'(LANES));
endmodule

// File: tb/lsu_split_unit_test.sv
`timescale 1ns/1ps
module lsu_split_unit_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic        req_valid, req_ready, req_write;
   logic [1:0]  req_size;
   logic [15:0] req_addr;
   logic [31:0] req_wdata;
   logic        mem_valid, mem_ready, mem_write;
   logic [15:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata, mem_rdata;
   logic        rsp_valid, rsp_fault;
   logic [1:0]  rsp_beats;
   logic [31:0] rsp_rdata;

   logic        s_req_valid, s_req_ready;
   logic [1:0]  s_req_size;
   logic [15:0] s_req_addr;
   logic        s_mem_valid, s_mem_write;
   logic [15:0] s_mem_addr;
   logic [3:0]  s_mem_be;
   logic [31:0] s_mem_wdata, s_mem_rdata;
   logic        s_rsp_valid, s_rsp_fault;
   logic [1:0]  s_rsp_beats;
   logic [31:0] s_rsp_rdata;

   lsu_split_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .mem_valid(mem_valid), .mem_ready(mem_ready),
      .mem_write(mem_write), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
      .rsp_fault(rsp_fault), .rsp_beats(rsp_beats), .rsp_rdata(rsp_rdata)
   );

   lsu_split_unit #(.STRICT_ALIGN(1'b1)) uut_strict (
      .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_ready(s_req_ready),
      .req_write(1'b0), .req_size(s_req_size), .req_addr(s_req_addr),
      .req_wdata(32'h0), .mem_valid(s_mem_valid), .mem_ready(1'b1),
      .mem_write(s_mem_write), .mem_addr(s_mem_addr), .mem_be(s_mem_be),
      .mem_wdata(s_mem_wdata), .mem_rdata(s_mem_rdata), .rsp_valid(s_rsp_valid),
      .rsp_fault(s_rsp_fault), .rsp_beats(s_rsp_beats), .rsp_rdata(s_rsp_rdata)
   );

   logic [7:0]  mem_b [0:63];
   logic [7:0]  ref_b [0:63];
   logic [3:0]  seen_be   [0:3];
   logic [15:0] seen_addr [0:3];
   int          bus_beats = 0;
   int          s_bus_beats = 0;
   int          errors = 0;
   int          checks = 0;
   bit          done = 1'b0;
   bit          stall_mode = 1'b0;
   int          rdy_cnt = 0;

   wire [5:0] ra  = mem_addr[5:0];
   wire [5:0] sra = s_mem_addr[5:0];
   assign mem_rdata   = {mem_b[{ra[5:2], 2'd3}], mem_b[{ra[5:2], 2'd2}],
                         mem_b[{ra[5:2], 2'd1}], mem_b[{ra[5:2], 2'd0}]};
   assign s_mem_rdata = {mem_b[{sra[5:2], 2'd3}], mem_b[{sra[5:2], 2'd2}],
                         mem_b[{sra[5:2], 2'd1}], mem_b[{sra[5:2], 2'd0}]};

   always @(posedge clk) begin
      if (mem_valid && mem_ready) begin
         seen_be[bus_beats % 4]   <= mem_be;
         seen_addr[bus_beats % 4] <= mem_addr;
         if (mem_write)
            for (int k = 0; k < 4; k++)
               if (mem_be[k]) mem_b[{ra[5:2], 2'(k)}] <= mem_wdata[8*k +: 8];
         bus_beats <= bus_beats + 1;
      end
      if (s_mem_valid) s_bus_beats <= s_bus_beats + 1;
   end

   always @(negedge clk) begin
      rdy_cnt   <= rdy_cnt + 1;
      mem_ready <= !stall_mode || (rdy_cnt % 3 == 2);
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // sizes: 0 byte, 1 halfword, 2 word
   task automatic run(input logic w, input logic [1:0] sz, input logic [15:0] ad,
                      input logic [31:0] wd, input int xb);
      int nb, base, waited;
      logic [31:0] xr;
      logic [3:0]  xbe0, xbe1;
      logic [15:0] wa0, b;
      bit same;
      nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      wa0  = ad & 16'hFFFC;
      xbe0 = 4'h0; xbe1 = 4'h0; xr = 32'h0;
      for (int k = 0; k < nb; k++) begin
         b = ad + 16'(k);
         if ((b & 16'hFFFC) == wa0) xbe0[b[1:0]] = 1'b1;
         else                       xbe1[b[1:0]] = 1'b1;
         xr[8*k +: 8] = ref_b[b[5:0]];
      end
      @(negedge clk);
      base = bus_beats;
      req_valid = 1'b1; req_write = w; req_size = sz; req_addr = ad; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R7 ready low while busy", 32'(req_ready), 32'h0);
      waited = 0;
      while (!rsp_valid && waited < 100) begin
         @(negedge clk);
         waited++;
      end
      chk(rsp_valid == 1'b1, "R7 response arrives", 32'(rsp_valid), 32'h1);
      chk(req_ready == 1'b0, "R7 ready low at response", 32'(req_ready), 32'h0);
      chk(32'(rsp_beats) == 32'(xb), "R3 reported beats", 32'(rsp_beats), 32'(xb));
      chk(bus_beats - base == xb, "R3 bus transfers", 32'(bus_beats - base), 32'(xb));
      chk(rsp_fault == 1'b0, "R8 no fault in split build", 32'(rsp_fault), 32'h0);
      chk(seen_addr[base % 4] == wa0, "R2 first word address",
          32'(seen_addr[base % 4]), 32'(wa0));
      chk(seen_be[base % 4] == xbe0, "R5 first lane enables",
          32'(seen_be[base % 4]), 32'(xbe0));
      if (xb == 2) begin
         chk(seen_addr[(base + 1) % 4] == wa0 + 16'd4, "R3 second word address",
             32'(seen_addr[(base + 1) % 4]), 32'(wa0 + 16'd4));
         chk(seen_be[(base + 1) % 4] == xbe1, "R5 second lane enables",
             32'(seen_be[(base + 1) % 4]), 32'(xbe1));
      end
      if (!w) chk(rsp_rdata == xr, "R4 load result", rsp_rdata, xr);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R7 response single pulse", 32'(rsp_valid), 32'h0);
      if (w) begin
         for (int k = 0; k < nb; k++) begin
            b = ad + 16'(k);
            ref_b[b[5:0]] = wd[8*k +: 8];
         end
         same = 1'b1;
         for (int i = 0; i < 64; i++) if (mem_b[i] !== ref_b[i]) same = 1'b0;
         chk(same, "R6 R5 memory image after store", 32'(same), 32'h1);
      end
   endtask

   task automatic srun(input logic [1:0] sz, input logic [15:0] ad,
                       input bit xf, input int xb);
      int base, waited, nb;
      logic [31:0] xr;
      logic [15:0] b;
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      xr = 32'h0;
      for (int k = 0; k < nb; k++) begin
         b = ad + 16'(k);
         xr[8*k +: 8] = ref_b[b[5:0]];
      end
      @(negedge clk);
      base = s_bus_beats;
      s_req_valid = 1'b1; s_req_size = sz; s_req_addr = ad;
      @(negedge clk);
      s_req_valid = 1'b0;
      waited = 0;
      while (!s_rsp_valid && waited < 100) begin
         @(negedge clk);
         waited++;
      end
      chk(s_rsp_valid == 1'b1, "R8 strict response", 32'(s_rsp_valid), 32'h1);
      chk(s_rsp_fault == xf, "R8 strict fault flag", 32'(s_rsp_fault), 32'(xf));
      chk(32'(s_rsp_beats) == 32'(xb), "R8 strict beats", 32'(s_rsp_beats), 32'(xb));
      chk(s_bus_beats - base == xb, "R8 strict bus transfers",
          32'(s_bus_beats - base), 32'(xb));
      if (!xf) chk(s_rsp_rdata == xr, "R8 strict aligned load", s_rsp_rdata, xr);
      @(negedge clk);
   endtask

   // {write, size, addr, wdata, expected beats}
   localparam int NV = 18;
   localparam logic [52:0] VEC [0:NV-1] = '{
      {1'b0, 2'd0, 16'h0005, 32'h0, 2'd1},
      {1'b0, 2'd1, 16'h0004, 32'h0, 2'd1},
      {1'b0, 2'd1, 16'h0005, 32'h0, 2'd1},
      {1'b0, 2'd1, 16'h0007, 32'h0, 2'd2},
      {1'b0, 2'd2, 16'h0008, 32'h0, 2'd1},
      {1'b0, 2'd2, 16'h0001, 32'h0, 2'd2},
      {1'b0, 2'd2, 16'h000E, 32'h0, 2'd2},
      {1'b0, 2'd2, 16'h0013, 32'h0, 2'd2},
      {1'b1, 2'd0, 16'h0021, 32'h000000A5, 2'd1},
      {1'b1, 2'd1, 16'h0023, 32'h00003C7E, 2'd2},
      {1'b1, 2'd2, 16'h0026, 32'hDEADBEEF, 2'd2},
      {1'b1, 2'd2, 16'h0030, 32'h12345678, 2'd1},
      {1'b1, 2'd1, 16'h0031, 32'h0000F00D, 2'd1},
      {1'b0, 2'd2, 16'h0020, 32'h0, 2'd1},
      {1'b0, 2'd2, 16'h0024, 32'h0, 2'd1},
      {1'b0, 2'd1, 16'h0023, 32'h0, 2'd2},
      {1'b0, 2'd2, 16'h002F, 32'h0, 2'd2},
      {1'b0, 2'd0, 16'h0033, 32'h0, 2'd1}
   };

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem_b[i] = 8'(i * 37 + 11);
         ref_b[i] = 8'(i * 37 + 11);
      end
      mem_ready = 1'b1;
      rst_n = 1'b0;
      req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0;
      req_addr = 16'h0; req_wdata = 32'h0;
      s_req_valid = 1'b0; s_req_size = 2'd0; s_req_addr = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'h0);
      chk(mem_valid == 1'b0, "R1 bus idle after reset", 32'(mem_valid), 32'h0);

      for (int v = 0; v < NV; v++)
         run(VEC[v][52], VEC[v][51:50], VEC[v][49:34], VEC[v][33:2], int'(VEC[v][1:0]));

      // R9: bus stalls leave results unchanged
      stall_mode = 1'b1;
      run(1'b0, 2'd2, 16'h0001, 32'h0, 2);
      run(1'b1, 2'd2, 16'h003A, 32'hCAFE1234, 2);
      run(1'b0, 2'd2, 16'h0038, 32'h0, 1);
      run(1'b0, 2'd2, 16'h003C, 32'h0, 1);
      run(1'b0, 2'd1, 16'h003B, 32'h0, 2);
      stall_mode = 1'b0;

      // R8: strict build faults on misalignment, serves aligned accesses
      srun(2'd1, 16'h0003, 1'b1, 0);
      srun(2'd2, 16'h0002, 1'b1, 0);
      srun(2'd1, 16'h0001, 1'b1, 0);
      srun(2'd2, 16'h0004, 1'b0, 1);
      srun(2'd0, 16'h0007, 1'b0, 1);
      srun(2'd1, 16'h0006, 1'b0, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      done = 1'b1;
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule